// File: doc/BRIEF.md
# Execution-Mode Memory Access Guard

This block sits between the CPU bus and the cores of a small single-processor system-on-chip. It decodes each CPU access into a target region and decides whether the access is allowed under the current execution mode. There are two modes. Firmware mode is entered at reset and may reach every region. Application mode is more restrictive. Firmware leaves its own mode by writing the mode control word. From then on the hardware stays in application mode until the next reset.

The block also holds the small control register set that belongs to the mode logic. This set is the mode word, the start address and size of the loaded application, and a 256-bit device identity value held as eight 32-bit words. Firmware fills these in. The application may only read them. Selects, grant and read data are registered and appear one clock after the access.

Top module: `exec_guard`

## Requirements
- R1: After a synchronous active-high reset the block is in firmware mode (`app_mode_o`=0), with `grant_o`=0, `sel_o`=0 and `rdata_o`=0. The start and size words read back 0.
- R2: A granted write to control word 0 in firmware mode sets `app_mode_o` to 1 at the same clock edge, and the write itself is granted. No later access clears the flag, and a write to word 0 in application mode is denied. Only reset returns the block to firmware mode.
- R3: The region is `addr_i[ADDR_W-1:ADDR_W-3]`: 0 boot ROM, 1 firmware RAM, 2 secret store, 3 application RAM, 4 timer, 5 UART, 6 control registers, 7 unmapped. A granted access to region i<6 raises only `sel_o[i]` one cycle later. `sel_o` is never more than one-hot.
- R4: The firmware RAM (read/write) and the secret store (read only) are granted only in firmware mode.
- R5: The boot ROM grants reads in both modes and denies writes. The application RAM, timer and UART grant reads and writes in both modes. Region 7 is always denied.
- R6: A denied access gives `grant_o`=0, `sel_o`=0 and `rdata_o`=0 in the following cycle. It has no effect on any control register or on the mode.
- R7: Control words are chosen by `addr_i[3:0]`. Word 0 is the mode, word 1 is the start address, word 2 is the size, and words 8 to 15 are identity words 0 to 7. Words 3 to 7 are denied. A granted control read returns the word on `rdata_o` one cycle later. Reads of other regions return 0 on `rdata_o`.
- R8: Writes to the start, size and identity words are granted only in firmware mode. Reads of these words are granted in both modes.
- R9: A read of word 0 returns `{31'b0, app_mode}` in either mode.
- R10: An access with `rd_i` and `wr_i` both high is handled as a write, and its `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | CPU word address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| sel_o | output | 6 | Registered one-hot select of the granted external region |
| grant_o | output | 1 | Registered grant for the previous cycle's access |
| rdata_o | output | DATA_W | Registered control-register read data |
| app_mode_o | output | 1 | Execution mode flag, 1 = application |

## Verification
The bench sweeps every region with both a read and a write, once in firmware mode and once in application mode. The expected grant comes from a permission formula, which separates the fw-only regions, the read-only regions and the shared regions. A second sweep covers all sixteen control words in each mode. Write-then-readback tells the denied words apart from the writable ones, and reading back after application-mode writes exposes any write that slipped through. Further cases cover the mode switch itself, a combined read and write strobe, and a second reset after application mode.

// File: rtl/guard_pkg.sv
package guard_pkg;

  typedef enum logic [2:0] {
    RG_ROM    = 3'd0,
    RG_FWRAM  = 3'd1,
    RG_SECRET = 3'd2,
    RG_APPRAM = 3'd3,
    RG_TIMER  = 3'd4,
    RG_UART   = 3'd5,
    RG_CTRL   = 3'd6,
    RG_NONE   = 3'd7
  } region_e;

  localparam int unsigned RG_BITS = 3;
  localparam int unsigned N_SEL   = 6;

  localparam int unsigned CW_MODE  = 0;
  localparam int unsigned CW_START = 1;
  localparam int unsigned CW_SIZE  = 2;

endpackage

// File: rtl/guard_decode.sv
module guard_decode
  import guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IDX_W  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              app_mode,
  output region_e           region,
  output logic [IDX_W-1:0]  idx,
  output logic              allow,
  output logic              ctrl_hit,
  output logic [N_SEL-1:0]  sel
);

  localparam int unsigned MID_W = ADDR_W - RG_BITS - IDX_W;

  logic req;
  logic ctrl_word_ok;
  logic unused_mid;

  assign region     = region_e'(addr[ADDR_W-1 -: RG_BITS]);
  assign idx        = addr[IDX_W-1:0];
  assign req        = rd | wr;
  assign unused_mid = ^addr[IDX_W +: MID_W];

  // Identity words live in the upper half of the control word space.
  always_comb begin
    ctrl_word_ok = idx[IDX_W-1] ||
                   (idx == IDX_W'(CW_MODE)) ||
                   (idx == IDX_W'(CW_START)) ||
                   (idx == IDX_W'(CW_SIZE));
  end

  always_comb begin
    allow = 1'b0;
    if (req) begin
      unique case (region)
        RG_ROM:    allow = !wr;
        RG_FWRAM:  allow = !app_mode;
        RG_SECRET: allow = !app_mode && !wr;
        RG_APPRAM,
        RG_TIMER,
        RG_UART:   allow = 1'b1;
        RG_CTRL:   allow = ctrl_word_ok && !(wr && app_mode);
        default:   allow = 1'b0;
      endcase
    end
  end

  assign ctrl_hit = allow && (region == RG_CTRL);

  for (genvar i = 0; i < N_SEL; i++) begin : g_sel
    assign sel[i] = allow && (region == region_e'(i));
  end

endmodule

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import guard_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ID_WORDS = 8,
  parameter int unsigned IDX_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic              wr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic              app_mode,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned ID_AW = $clog2(ID_WORDS);

  logic [DATA_W-1:0] start_q;
  logic [DATA_W-1:0] size_q;
  logic [DATA_W-1:0] id_mem [ID_WORDS];
  logic              id_hit;
  logic [ID_AW-1:0]  id_addr;

  assign id_hit  = idx[IDX_W-1];
  assign id_addr = idx[ID_AW-1:0];

  // Mode flag and info words: reset state, firmware writes only (gated upstream).
  always_ff @(posedge clk) begin
    if (rst) begin
      app_mode <= 1'b0;
      start_q  <= '0;
      size_q   <= '0;
    end else if (acc && wr && !id_hit) begin
      unique case (idx)
        IDX_W'(CW_MODE):  app_mode <= 1'b1;
        IDX_W'(CW_START): start_q  <= wdata;
        IDX_W'(CW_SIZE):  size_q   <= wdata;
        default: ;
      endcase
    end
  end

  // Identity words: plain synchronous-write array without reset.
  always_ff @(posedge clk) begin
    if (acc && wr && id_hit) begin
      id_mem[id_addr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !acc || wr) begin
      rdata <= '0;
    end else if (id_hit) begin
      rdata <= id_mem[id_addr];
    end else begin
      unique case (idx)
        IDX_W'(CW_MODE):  rdata <= DATA_W'(app_mode);
        IDX_W'(CW_START): rdata <= start_q;
        IDX_W'(CW_SIZE):  rdata <= size_q;
        default:          rdata <= '0;
      endcase
    end
  end

  // R2: the application mode flag is one-way until reset
  a_r2_mode_sticky: assert property (@(posedge clk) disable iff (rst)
    app_mode |=> app_mode);

  // R8: info words cannot change once in application mode
  a_r8_info_frozen: assert property (@(posedge clk) disable iff (rst)
    app_mode |=> ($stable(start_q) && $stable(size_q)));

  // R10: a write never produces read data
  a_r10_write_no_data: assert property (@(posedge clk) disable iff (rst)
    (acc && wr) |=> (rdata == '0));

endmodule

// File: rtl/exec_guard.sv
module exec_guard
  import guard_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ID_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [5:0]        sel_o,
  output logic              grant_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              app_mode_o
);

  localparam int unsigned IDX_W = $clog2(ID_WORDS) + 1;

  region_e          region;
  logic [IDX_W-1:0] idx;
  logic             allow;
  logic             ctrl_hit;
  logic [N_SEL-1:0] sel;
  logic             app_mode;

  guard_decode #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
  ) u_decode (
    .addr     (addr_i),
    .rd       (rd_i),
    .wr       (wr_i),
    .app_mode (app_mode),
    .region   (region),
    .idx      (idx),
    .allow    (allow),
    .ctrl_hit (ctrl_hit),
    .sel      (sel)
  );

  guard_ctrl #(
    .DATA_W   (DATA_W),
    .ID_WORDS (ID_WORDS),
    .IDX_W    (IDX_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .acc      (ctrl_hit),
    .wr       (wr_i),
    .idx      (idx),
    .wdata    (wdata_i),
    .app_mode (app_mode),
    .rdata    (rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o   <= '0;
      grant_o <= 1'b0;
    end else begin
      sel_o   <= sel;
      grant_o <= allow;
    end
  end

  assign app_mode_o = app_mode;

  // R4: firmware-private regions are unreachable from application mode
  a_r4_fw_private: assert property (@(posedge clk) disable iff (rst)
    (app_mode_o && (rd_i || wr_i) &&
     ((region == RG_FWRAM) || (region == RG_SECRET))) |=> !grant_o);

  // R3: at most one region select
  a_r3_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_o));

  // R6: a denied or idle cycle is quiet on the outputs
  a_r6_denied_quiet: assert property (@(posedge clk) disable iff (rst)
    !grant_o |-> ((sel_o == '0) && (rdata_o == '0)));

  // R5: the unmapped region is never granted
  a_r5_unmapped: assert property (@(posedge clk) disable iff (rst)
    ((rd_i || wr_i) && (region == RG_NONE)) |=> !grant_o);

endmodule

// File: tb/exec_guard_test.sv
module exec_guard_test;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] addr_i;
  logic        rd_i, wr_i;
  logic [31:0] wdata_i;
  logic [5:0]  sel_o;
  logic        grant_o;
  logic [31:0] rdata_o;
  logic        app_mode_o;

  always #5 clk = ~clk;

  exec_guard uut (
    .clk(clk), .rst(rst), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .sel_o(sel_o), .grant_o(grant_o),
    .rdata_o(rdata_o), .app_mode_o(app_mode_o)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_val [16];
  logic        g;
  logic [5:0]  s;
  logic [31:0] r;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input int rg, input int idx, input bit rdb, input bit wrb,
                        input logic [31:0] d);
    @(negedge clk);
    addr_i  = {rg[2:0], 9'h0A5, idx[3:0]};
    rd_i    = rdb;
    wr_i    = wrb;
    wdata_i = d;
    @(negedge clk);
    g = grant_o; s = sel_o; r = rdata_o;
    rd_i = 1'b0; wr_i = 1'b0;
  endtask

  function automatic bit ctrl_ok(input int idx);
    return (idx <= 2) || (idx >= 8);
  endfunction

  function automatic bit exp_grant(input bit app, input int rg, input int idx, input bit w);
    case (rg)
      0: return !w;
      1: return !app;
      2: return !app && !w;
      3, 4, 5: return 1'b1;
      6: return ctrl_ok(idx) && !(w && app);
      default: return 1'b0;
    endcase
  endfunction

  task automatic region_sweep(input bit app);
    for (int rg = 0; rg < 8; rg++) begin
      for (int w = 0; w < 2; w++) begin
        bit eg;
        eg = exp_grant(app, rg, 1, w[0]);
        access(rg, 1, !w[0], w[0], 32'h0000_1000 + rg);
        if (rg == 6 && eg && w[0]) exp_val[1] = 32'h0000_1000 + rg;
        chk($sformatf("R4 R5 grant mode=%0d rg=%0d wr=%0d", app, rg, w), g, eg);
        chk($sformatf("R3 R6 sel mode=%0d rg=%0d wr=%0d", app, rg, w),
            s, (eg && rg < 6) ? (6'd1 << rg) : 6'd0);
        if (rg != 6)
          chk($sformatf("R7 rdata zero rg=%0d", rg), r, 32'h0);
      end
    end
  endtask

  task automatic ctrl_write_sweep(input bit app);
    for (int i = 1; i < 16; i++) begin
      bit eg;
      logic [31:0] d;
      d  = 32'hA5A5_0000 ^ (i * 32'h1111_0101) ^ {31'h0, app};
      eg = exp_grant(app, 6, i, 1'b1);
      access(6, i, 1'b0, 1'b1, d);
      if (eg) exp_val[i] = d;
      chk($sformatf("R8 ctrl write grant mode=%0d word=%0d", app, i), g, eg);
    end
  endtask

  task automatic ctrl_read_sweep(input bit app);
    exp_val[0] = {31'h0, app};
    for (int i = 0; i < 16; i++) begin
      bit eg;
      eg = ctrl_ok(i);
      access(6, i, 1'b1, 1'b0, 32'h0);
      chk($sformatf("R7 R8 ctrl read grant mode=%0d word=%0d", app, i), g, eg);
      chk($sformatf("R7 R9 ctrl read data mode=%0d word=%0d", app, i), r,
          eg ? exp_val[i] : 32'h0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) exp_val[i] = 32'h0;
    addr_i = '0; rd_i = 0; wr_i = 0; wdata_i = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset mode", app_mode_o, 0);
    chk("R1 reset grant", grant_o, 0);
    chk("R1 reset sel", sel_o, 0);
    chk("R1 reset rdata", rdata_o, 0);
    rst = 1'b0;

    // firmware mode
    region_sweep(1'b0);
    ctrl_write_sweep(1'b0);
    ctrl_read_sweep(1'b0);

    // R10: read and write together count as a write
    access(6, 1, 1'b1, 1'b1, 32'hCAFE_0001);
    exp_val[1] = 32'hCAFE_0001;
    chk("R10 dual strobe grant", g, 1);
    chk("R10 dual strobe rdata", r, 0);
    access(6, 1, 1'b1, 1'b0, 32'h0);
    chk("R10 dual strobe wrote", r, 32'hCAFE_0001);

    // R2: switch to application mode
    chk("R2 still firmware", app_mode_o, 0);
    access(6, 0, 1'b0, 1'b1, 32'h0);
    chk("R2 mode write grant", g, 1);
    chk("R2 mode set", app_mode_o, 1);

    // application mode
    region_sweep(1'b1);
    access(6, 0, 1'b0, 1'b1, 32'h0);
    chk("R2 mode write denied in app", g, 0);
    chk("R2 mode stays app", app_mode_o, 1);
    ctrl_write_sweep(1'b1);
    chk("R6 mode unchanged by denied writes", app_mode_o, 1);
    ctrl_read_sweep(1'b1);

    // R1: reset returns to firmware mode and clears info words
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 reset after app mode", app_mode_o, 0);
    access(6, 1, 1'b1, 1'b0, 32'h0);
    chk("R1 start cleared", r, 0);
    access(6, 2, 1'b1, 1'b0, 32'h0);
    chk("R1 size cleared", r, 0);
    access(1, 3, 1'b1, 1'b0, 32'h0);
    chk("R4 fw RAM open again", g, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule